// File: doc/BRIEF.md
# NAND Flash Device Command Responder

This block is a synthesizable device-side model of a byte-wide NAND flash part. It sits on the flash side of a controller under test and answers that controller. It watches the command-latch, address-latch, write-strobe and read-strobe lines on an 8-bit bus. It decodes commands and gathers address bytes, and it keeps an output mode that chooses what appears on the data-out bus: array data, the status byte or the identification bytes.

The block models page reads, page programs, block erases and reset. Each internal operation holds the ready/busy line low for a number of clocks set by a parameter. A small page buffer collects program data. A small backing array, sized by parameters to a few blocks, holds the stored bytes.

All strobes are sampled in the `clk` domain. A write-strobe rising edge latches the bus, and a read-strobe rising edge advances the output. Default geometry is 16 bytes per page, 4 pages per block and 4 blocks. The page index is the row address modulo 16, the block is the page index divided by 4, and the column is the low 4 bits of the column byte. After reset every stored byte reads FFh.

Top module: `nand_cmd_responder`

## Requirements
- R1: After reset `rb_n` is high, the output mode is array read, and three address cycles issued with no command start a page read that holds `rb_n` low for exactly T_READ clocks.
- R2: Command 00h followed by column, row-low and row-high address bytes holds `rb_n` low for T_READ clocks. Then `dout` shows the stored byte at that column, and each read-strobe cycle advances the column, which stops at the last column of the page.
- R3: While the output mode is array read, three further address cycles with no new command start another page read at the new column and row.
- R4: Command 80h, three address bytes, data bytes and then 10h holds `rb_n` low for T_PROG clocks. Afterwards the page holds the written bytes from the given column on, and every column that was not written holds FFh.
- R5: A 10h command that does not follow a finished 80h address sequence has no effect: `rb_n` stays high and the output mode and read position are unchanged.
- R6: Command 60h, two row bytes and then D0h holds `rb_n` low for T_ERASE clocks and sets every byte of the addressed block to FFh. The page-within-block bits of the row are ignored.
- R7: Starting a program or an erase switches the output to the status byte without a 70h command, and the status stays there until another command is accepted. Status bit 7 equals `wp_n`, bit 6 is 1 when ready, bit 0 is 1 when the last program or erase failed, and all other bits are 0.
- R8: While busy, only 70h and FFh are accepted. Every other command, and every address cycle, is ignored.
- R9: Command FFh aborts any running operation at once: `rb_n` goes high and the array is not updated. It clears the fail flag and returns to array-read mode, so with `wp_n` high a following 70h reads C0h.
- R10: A program or erase started with `wp_n` low runs its busy period, leaves the array unchanged, and afterwards reads status 41h.
- R11: Command 90h followed by address 00h makes `dout` show ECh. After one read-strobe cycle it shows 76h, and it stays at 76h until a new command arrives.
- R12: A D0h command that does not follow 60h and two row bytes has no effect: `rb_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| wp_n | input | 1 | Write protect, low blocks program and erase |
| cle | input | 1 | Bus cycle carries a command |
| ale | input | 1 | Bus cycle carries an address byte |
| we_n | input | 1 | Write strobe, bus latched on its rising edge |
| re_n | input | 1 | Read strobe, output advances on its rising edge |
| din | input | 8 | Bus byte from the controller |
| dout | output | 8 | Bus byte to the controller |
| rb_n | output | 1 | Ready (high) or busy (low) |

## Verification
A wrong setup state shows up quickly at the ports. A confirm command that should be ignored starts a busy period, and `rb_n` drops one clock after the write-strobe edge. A wrong output mode shows within a single read cycle, because `dout` then carries status, ID or array bytes where another kind was expected. A fault in the array commit or in the column pointer shows only on the next page read of the affected page, which comes at least T_READ clocks after its address.

// File: rtl/nand_resp_pkg.sv
`timescale 1ns/1ps
package nand_resp_pkg;
  typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_IDENT} out_mode_e;
  typedef enum logic [2:0] {SU_NONE, SU_RD_ADDR, SU_PG_ADDR, SU_PG_DATA,
                            SU_ER_ADDR, SU_ID_ADDR} setup_e;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} op_e;

  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_RESET    = 8'hFF;
  localparam logic [7:0] MAKER_CODE   = 8'hEC;
  localparam logic [7:0] DEVICE_CODE  = 8'h76;

  // status: write-enable, ready, fail
  function automatic logic [7:0] status_byte(input logic wp_n, input logic busy,
                                             input logic fail);
    return {wp_n, ~busy, 5'b00000, fail};
  endfunction

  // row address folded onto the backing array
  function automatic int page_of(input logic [15:0] row, input int pages);
    return int'(row) % pages;
  endfunction

  function automatic int byte_index(input int page, input int col, input int page_bytes);
    return page * page_bytes + col;
  endfunction
endpackage

// File: rtl/nand_strobe_edge.sv
`timescale 1ns/1ps
module nand_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise,
  output logic fall
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  assign rise = strobe_n & ~prev_q;
  assign fall = ~strobe_n & prev_q;
endmodule

// File: rtl/nand_busy_timer.sv
`timescale 1ns/1ps
module nand_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             abort,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt_q <= '0;
    else if (abort)         cnt_q <= '0;
    else if (start)         cnt_q <= load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1)) & ~abort;

  // busy only ends through completion or abort (R2)
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done || abort));
  // a start with nonzero length raises busy (R4)
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && load != '0) |=> busy);
endmodule

// File: rtl/nand_page_store.sv
`timescale 1ns/1ps
module nand_page_store #(
  parameter int PAGE_BYTES    = 16,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 4
) (
  clk, rst_n, buf_clr, buf_wr, buf_col, buf_data,
  commit_prog, commit_erase, page_sel, blk_sel, rd_col, rd_data
);
  localparam int PAGES     = PAGES_PER_BLK * BLOCKS;
  localparam int MEM_BYTES = PAGES * PAGE_BYTES;
  localparam int BLK_BYTES = PAGES_PER_BLK * PAGE_BYTES;
  localparam int COL_W     = $clog2(PAGE_BYTES);
  localparam int PI_W      = $clog2(PAGES);
  localparam int BLK_W     = $clog2(BLOCKS);
  localparam int MEM_AW    = $clog2(MEM_BYTES);

  input  logic             clk;
  input  logic             rst_n;
  input  logic             buf_clr;
  input  logic             buf_wr;
  input  logic [COL_W-1:0] buf_col;
  input  logic [7:0]       buf_data;
  input  logic             commit_prog;
  input  logic             commit_erase;
  input  logic [PI_W-1:0]  page_sel;
  input  logic [BLK_W-1:0] blk_sel;
  input  logic [COL_W-1:0] rd_col;
  output logic [7:0]       rd_data;

  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++)  mem[i]  <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else begin
      if (buf_clr)
        for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      else if (buf_wr)
        pbuf[buf_col] <= buf_data;
      if (commit_prog)
        for (int i = 0; i < PAGE_BYTES; i++)
          mem[MEM_AW'(nand_resp_pkg::byte_index(int'(page_sel), i, PAGE_BYTES))] <= pbuf[i];
      if (commit_erase)
        for (int i = 0; i < BLK_BYTES; i++)
          mem[MEM_AW'(int'(blk_sel) * BLK_BYTES + i)] <= 8'hFF;
    end
  end

  assign rd_data = mem[MEM_AW'(nand_resp_pkg::byte_index(int'(page_sel), int'(rd_col), PAGE_BYTES))];

  // the two commits never overlap (R4, R6)
  p_one_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_prog && commit_erase));
endmodule

// File: rtl/nand_cmd_responder.sv
`timescale 1ns/1ps
module nand_cmd_responder #(
  parameter int PAGE_BYTES    = 16,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 4,
  parameter int T_READ        = 5,
  parameter int T_PROG        = 12,
  parameter int T_ERASE       = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       rb_n
);
  import nand_resp_pkg::*;

  localparam int PAGES = PAGES_PER_BLK * BLOCKS;
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int PI_W  = $clog2(PAGES);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int T_MAX = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                            : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  out_mode_e        mode_q;
  setup_e           setup_q;
  op_e              op_q;
  logic [1:0]       acnt_q;
  logic [COL_W-1:0] ptr_q;
  logic [15:0]      row_q;
  logic             fail_q, id_dev_q;

  // named internal events
  logic we_rise, re_rise, we_fall_unused, re_fall_unused;
  logic cmd_ev, addr_ev, data_ev, busy, done;
  logic reset_cmd, status_cmd, start_read, start_prog, start_erase, rd_collect;
  logic [CNT_W-1:0] busy_load;
  logic [PI_W-1:0]  page_idx;
  logic [BLK_W-1:0] blk_idx;
  logic [7:0]       arr_byte;

  nand_strobe_edge i_we_edge (.clk(clk), .rst_n(rst_n), .strobe_n(we_n),
                              .rise(we_rise), .fall(we_fall_unused));
  nand_strobe_edge i_re_edge (.clk(clk), .rst_n(rst_n), .strobe_n(re_n),
                              .rise(re_rise), .fall(re_fall_unused));

  assign cmd_ev      = we_rise & cle & ~ale;
  assign addr_ev     = we_rise & ale & ~cle;
  assign data_ev     = we_rise & ~ale & ~cle;
  assign reset_cmd   = cmd_ev & (din == CMD_RESET);
  assign status_cmd  = cmd_ev & (din == CMD_STATUS);
  assign start_prog  = cmd_ev & ~busy & (din == CMD_PROG_GO) & (setup_q == SU_PG_DATA);
  assign start_erase = cmd_ev & ~busy & (din == CMD_ERASE_GO) & (setup_q == SU_ER_ADDR)
                     & (acnt_q == 2'd2);
  assign rd_collect  = addr_ev & ~busy & ((setup_q == SU_RD_ADDR) |
                       ((setup_q == SU_NONE) & (mode_q == OUT_ARRAY)));
  assign start_read  = rd_collect & (acnt_q == 2'd2);
  assign busy_load   = start_erase ? CNT_W'(T_ERASE) : start_prog ? CNT_W'(T_PROG)
                                                      : CNT_W'(T_READ);

  nand_busy_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start_read | start_prog | start_erase),
    .load(busy_load), .abort(reset_cmd), .busy(busy), .done(done));

  assign page_idx = PI_W'(page_of(row_q, PAGES));
  assign blk_idx  = BLK_W'(page_of(row_q, PAGES) / PAGES_PER_BLK);

  nand_page_store #(.PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLK(PAGES_PER_BLK),
                    .BLOCKS(BLOCKS)) i_store (
    .clk(clk), .rst_n(rst_n),
    .buf_clr(cmd_ev & ~busy & (din == CMD_PROG)),
    .buf_wr(data_ev & ~busy & (setup_q == SU_PG_DATA)),
    .buf_col(ptr_q), .buf_data(din),
    .commit_prog(done & (op_q == OP_PROG) & ~fail_q),
    .commit_erase(done & (op_q == OP_ERASE) & ~fail_q),
    .page_sel(page_idx), .blk_sel(blk_idx), .rd_col(ptr_q), .rd_data(arr_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OUT_ARRAY; setup_q <= SU_NONE; op_q <= OP_NONE; acnt_q <= '0;
      ptr_q <= '0; row_q <= '0; fail_q <= 1'b0; id_dev_q <= 1'b0;
    end else if (reset_cmd) begin
      mode_q <= OUT_ARRAY; setup_q <= SU_NONE; op_q <= OP_NONE; acnt_q <= '0;
      fail_q <= 1'b0; id_dev_q <= 1'b0;
    end else if (status_cmd) begin
      mode_q <= OUT_STATUS;
      if (!busy) setup_q <= SU_NONE;
    end else if (cmd_ev && !busy) begin
      acnt_q <= '0;
      unique case (din)
        CMD_READ:  begin mode_q <= OUT_ARRAY; setup_q <= SU_RD_ADDR; end
        CMD_PROG:  setup_q <= SU_PG_ADDR;
        CMD_ERASE: setup_q <= SU_ER_ADDR;
        CMD_IDENT: setup_q <= SU_ID_ADDR;
        CMD_PROG_GO, CMD_ERASE_GO:
          if (start_prog || start_erase) begin
            mode_q <= OUT_STATUS; setup_q <= SU_NONE; fail_q <= ~wp_n;
            op_q <= start_prog ? OP_PROG : OP_ERASE;
          end else acnt_q <= acnt_q;
        default: acnt_q <= acnt_q;
      endcase
    end else if (addr_ev && !busy) begin
      if (rd_collect || setup_q == SU_PG_ADDR) begin
        unique case (acnt_q)
          2'd0:    begin ptr_q <= din[COL_W-1:0]; acnt_q <= 2'd1; end
          2'd1:    begin row_q[7:0] <= din; acnt_q <= 2'd2; end
          default: begin
            row_q[15:8] <= din; acnt_q <= '0;
            if (rd_collect) begin setup_q <= SU_NONE; op_q <= OP_READ; end
            else setup_q <= SU_PG_DATA;
          end
        endcase
      end else if (setup_q == SU_ER_ADDR) begin
        if (acnt_q == 2'd0)      begin row_q[7:0]  <= din; acnt_q <= 2'd1; end
        else if (acnt_q == 2'd1) begin row_q[15:8] <= din; acnt_q <= 2'd2; end
      end else if (setup_q == SU_ID_ADDR && din == 8'h00) begin
        mode_q <= OUT_IDENT; setup_q <= SU_NONE; id_dev_q <= 1'b0;
      end
    end else if (data_ev && !busy && setup_q == SU_PG_DATA) begin
      if (ptr_q != LAST_COL) ptr_q <= ptr_q + 1'b1;
    end else if (re_rise && !busy) begin
      if (mode_q == OUT_ARRAY && ptr_q != LAST_COL) ptr_q <= ptr_q + 1'b1;
      if (mode_q == OUT_IDENT) id_dev_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode_q)
      OUT_STATUS: dout = status_byte(wp_n, busy, fail_q);
      OUT_IDENT:  dout = id_dev_q ? DEVICE_CODE : MAKER_CODE;
      default:    dout = arr_byte;
    endcase
  end
  assign rb_n = ~busy;

  p_confirm_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> !rb_n);
  p_orphan_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !busy && din == CMD_PROG_GO && setup_q != SU_PG_DATA) |=> rb_n);
  p_auto_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |=> (mode_q == OUT_STATUS));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmd_ev && din != CMD_STATUS && din != CMD_RESET)
      |=> ($stable(mode_q) && $stable(setup_q)));
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (rb_n && !fail_q && mode_q == OUT_ARRAY));
  p_orphan_erase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !busy && din == CMD_ERASE_GO && setup_q != SU_ER_ADDR) |=> rb_n);
endmodule

// File: tb/test_nand_cmd_responder.sv
`timescale 1ns/1ps
module test_nand_cmd_responder;
  localparam int T_READ = 5, T_PROG = 12, T_ERASE = 20;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic we_n = 1'b1, re_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic rb_n;
  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       ev_obs;

  always #5 clk = ~clk;

  nand_cmd_responder #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) i_nand_cmd_responder (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .din(din), .dout(dout), .rb_n(rb_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as read cycles produce them
  initial forever begin
    @(ev_obs);
    if (exp_q.size() == 0) check(0, "scoreboard underflow", obs, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(obs === e, t, obs, e);
    end
  end

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; din = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] d);  bus_wr(1'b1, 1'b0, d); endtask
  task automatic addr(input logic [7:0] d); bus_wr(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  bus_wr(1'b0, 1'b0, d); endtask

  task automatic rd_expect(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); obs = dout; -> ev_obs; re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rb_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic addr3(input logic [7:0] col, input logic [7:0] row);
    addr(col); addr(row); addr(8'h00);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rb_n === 1'b1, "R1 ready after reset", rb_n, 1);
    // R1 R3: address-only read from power-on mode
    addr3(8'h00, 8'h00); wait_ready(n);
    check(n == T_READ, "R1 busy length of address-only read", n, T_READ);
    rd_expect(8'hFF, "R1 erased array byte");
    cmd(8'h70); rd_expect(8'hC0, "R7 status after reset");
    // R11 identification
    cmd(8'h90); addr(8'h00);
    rd_expect(8'hEC, "R11 maker code");
    rd_expect(8'h76, "R11 device code");
    rd_expect(8'h76, "R11 stays on device code");
    // R4 program page 5 col 2
    cmd(8'h80); addr3(8'h02, 8'h05); dat(8'hA1); dat(8'hB2); dat(8'hC3);
    cmd(8'h10); wait_ready(n);
    check(n == T_PROG, "R4 program busy length", n, T_PROG);
    rd_expect(8'hC0, "R7 auto status after program");
    rd_expect(8'hC0, "R7 status persists");
    // R2 read back
    cmd(8'h00); addr3(8'h00, 8'h05); wait_ready(n);
    check(n == T_READ, "R2 read busy length", n, T_READ);
    rd_expect(8'hFF, "R4 unwritten col0");
    rd_expect(8'hFF, "R4 unwritten col1");
    rd_expect(8'hA1, "R2 col2");
    rd_expect(8'hB2, "R2 col3");
    rd_expect(8'hC3, "R2 col4");
    rd_expect(8'hFF, "R4 unwritten col5");
    // R3 persistent read mode
    addr3(8'h03, 8'h05); wait_ready(n);
    check(n == T_READ, "R3 persistent read busy", n, T_READ);
    rd_expect(8'hB2, "R3 persistent read data");
    // R2 last-column stop on page 6
    cmd(8'h80); addr3(8'h0E, 8'h06); dat(8'h11); dat(8'h22); cmd(8'h10); wait_ready(n);
    cmd(8'h00); addr3(8'h0E, 8'h06); wait_ready(n);
    rd_expect(8'h11, "R2 col14");
    rd_expect(8'h22, "R2 col15");
    rd_expect(8'h22, "R2 stops at last column");
    // R5 orphan program confirm
    cmd(8'h10);
    check(rb_n === 1'b1, "R5 orphan 10h leaves ready", rb_n, 1);
    rd_expect(8'h22, "R5 read mode and position kept");
    // R6 erase block 0, measured
    cmd(8'h60); addr(8'h01); addr(8'h00); cmd(8'hD0); wait_ready(n);
    check(n == T_ERASE, "R6 erase busy length", n, T_ERASE);
    rd_expect(8'hC0, "R7 auto status after erase");
    // R6 R8 erase block 1 via row 6 (page bits nonzero), commands during busy
    cmd(8'h60); addr(8'h06); addr(8'h00); cmd(8'hD0);
    cmd(8'h00); addr(8'h00);
    rd_expect(8'h80, "R8 read command ignored while busy");
    cmd(8'h70);
    rd_expect(8'h80, "R8 status command accepted while busy");
    wait_ready(n);
    rd_expect(8'hC0, "R7 ready bit set after erase");
    cmd(8'h00); addr3(8'h02, 8'h05); wait_ready(n);
    rd_expect(8'hFF, "R6 page5 erased");
    cmd(8'h00); addr3(8'h0E, 8'h06); wait_ready(n);
    rd_expect(8'hFF, "R6 page6 erased");
    // R9 reset aborts program of page 9
    cmd(8'h80); addr3(8'h00, 8'h09); dat(8'h55); cmd(8'h10);
    cmd(8'hFF);
    check(rb_n === 1'b1, "R9 reset ends busy", rb_n, 1);
    cmd(8'h70); rd_expect(8'hC0, "R9 status C0 after reset");
    cmd(8'h00); addr3(8'h00, 8'h09); wait_ready(n);
    rd_expect(8'hFF, "R9 aborted program not stored");
    // R10 write protected program
    wp_n = 1'b0;
    cmd(8'h80); addr3(8'h00, 8'h0A); dat(8'h77); cmd(8'h10); wait_ready(n);
    check(n == T_PROG, "R10 protected program still busy", n, T_PROG);
    rd_expect(8'h41, "R10 fail status");
    wp_n = 1'b1;
    cmd(8'h00); addr3(8'h00, 8'h0A); wait_ready(n);
    rd_expect(8'hFF, "R10 array unchanged");
    // R12 orphan erase confirm
    cmd(8'hD0);
    check(rb_n === 1'b1, "R12 orphan D0h", rb_n, 1);
    cmd(8'h60); addr(8'h04); cmd(8'hD0);
    check(rb_n === 1'b1, "R12 D0h after one row byte", rb_n, 1);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule